// File: doc/BRIEF.md
# CAN Bit Timing and Arbitration Engine

This block turns a fast system clock into the bit timing of one CAN node. A programmable prescaler produces the time quantum (tq). Each nominal bit is N quanta long, with N between 9 and 20. The receive line passes through a two-flop synchroniser. It is then sampled once per bit, at the end of a programmable quantum S. Every recessive-to-dominant edge on the line is located within the current bit. When it is early or late relative to the sample point, the current bit is lengthened or shortened by one quantum so that the node keeps phase with the other transmitters on the bus.

The bus is a wired-AND of all transmitters: dominant is logic 0, recessive is logic 1, and an undriven bus reads recessive. A controlling framer holds `tx_req` high for the length of a transmission and presents each serial bit on `tx_bit` while `bit_stb` is high. If the node sends recessive but samples dominant, it has lost arbitration. It releases the bus at once and raises `arb_lost`. The flag and the released bus hold until the framer starts a new transmission. Timing configuration is taken from the configuration inputs only while no transmission is active. Out-of-range values are clamped.

Top module: `can_bit_timer`

## Requirements
- R1: After reset `tx_out` is 1 (recessive), `arb_lost` is 0, and `sample_stb` and `bit_stb` are 0.
- R2: With a quiet bus, successive `bit_stb` pulses are N*(cfg_brp+1) clocks apart. N is `cfg_ntq` clamped into 9..20.
- R3: `sample_stb` pulses once per bit, S*(cfg_brp+1) clocks after the preceding `bit_stb`. S is `cfg_sp` clamped into 2..N-1. `sample_bit` carries the bus level at that point (1 recessive, 0 dominant).
- R4: A recessive-to-dominant edge in quantum k of a bit, with quanta numbered 1..N from the bit start and 2 <= k <= S-1, makes that bit N+1 quanta long.
- R5: A recessive-to-dominant edge in quantum k, with S+1 <= k <= N, ends that bit at the end of quantum max(k, N-1).
- R6: An edge in quantum 1 or in quantum S causes no adjustment. Rising edges are never used. Only the first qualifying edge in a bit adjusts it. The next bit is nominal again.
- R7: While `tx_req` is high and arbitration is held, `tx_out` equals the `tx_bit` value captured on the cycle `tx_req` first rises or on a `bit_stb` cycle, and it changes one clock later. With `tx_req` low, `tx_out` is 1.
- R8: When the node sends 1 and the sample reads 0, `arb_lost` is 1 and `tx_out` is 1 from the clock after `sample_stb`.
- R9: Sending 0, or sending 1 and sampling 1, never raises `arb_lost`.
- R10: After a loss, `tx_out` stays 1 whatever `tx_bit` does, and `arb_lost` stays 1, until `tx_req` goes low and rises again. That restart clears `arb_lost`.
- R11: Changes on `cfg_brp`, `cfg_ntq` and `cfg_sp` during a transmission do not alter bit timing. They take effect once `tx_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_brp | input | BRP_W | Quantum length minus one, in clocks |
| cfg_ntq | input | 5 | Quanta per bit, clamped to 9..20 |
| cfg_sp | input | 5 | Quantum at whose end the bit is sampled, clamped to 2..N-1 |
| tx_req | input | 1 | High for the duration of a transmission; a rising level starts one |
| tx_bit | input | 1 | Next serial bit to send, taken on `bit_stb` |
| rx_in | input | 1 | Bus receive level (asynchronous) |
| tx_out | output | 1 | Bus transmit level, 0 dominant |
| arb_lost | output | 1 | Arbitration lost during the current transmission |
| sample_stb | output | 1 | One-cycle strobe marking the sample point |
| sample_bit | output | 1 | Bus level sampled at the last sample point |
| bit_stb | output | 1 | One-cycle bit-boundary strobe |

## Verification
Random prescaler, bit-length and sample-point settings on a quiet bus separate errors in quantum counting from errors in sample placement. The clamping corners probe the range limits. Single falling edges placed mid-quantum in every zone of the bit, namely quantum 1, before S, at S, after S and the final two quanta, distinguish lengthen, shorten and no-adjust. A pair of edges in one bit, and the bit that follows each adjustment, show that only one correction is made and that it does not persist. Transmit patterns of dominant-over-dominant, recessive-over-recessive and recessive-over-dominant separate a true arbitration loss from a matching bit. Changes on `tx_bit` after a loss, a restart, and configuration writes during a transmission confirm the hold behaviour.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    localparam int NTQ_MIN = 9;
    localparam int NTQ_MAX = 20;
    localparam int QW      = 5;

    typedef logic [QW-1:0] quanta_t;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_LONG  = 2'd1,
        ADJ_SHORT = 2'd2
    } adj_e;

    function automatic quanta_t clamp_ntq(input quanta_t v);
        if (v < quanta_t'(NTQ_MIN)) return quanta_t'(NTQ_MIN);
        if (v > quanta_t'(NTQ_MAX)) return quanta_t'(NTQ_MAX);
        return v;
    endfunction

    function automatic quanta_t clamp_sp(input quanta_t v, input quanta_t n);
        if (v < quanta_t'(2)) return quanta_t'(2);
        if (v > n - quanta_t'(1)) return n - quanta_t'(1);
        return v;
    endfunction
endpackage

// File: rtl/can_tq_prescaler.sv
module can_tq_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_tick
);
    typedef struct packed {
        logic [BRP_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign tq_tick = (st_q.cnt >= brp);

    always_comb begin
        st_d = st_q;
        if (tq_tick) st_d.cnt = '0;
        else         st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/can_rx_sync.sv
module can_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_lvl,
    output logic fall_pulse
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } st_t;

    st_t st_d, st_q;

    assign rx_lvl     = st_q.s2;
    assign fall_pulse = st_q.s3 & ~st_q.s2;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = rx_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/can_bit_engine.sv
module can_bit_engine
    import can_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tq_tick,
    input  quanta_t ntq,
    input  quanta_t sp,
    input  logic    rx_lvl,
    input  logic    fall_pulse,
    output logic    sample_stb,
    output logic    sample_bit,
    output logic    bit_stb
);
    typedef struct packed {
        quanta_t q_cnt;
        adj_e    adj;
        logic    edge_seen;
        logic    sample_stb;
        logic    sample_bit;
        logic    bit_stb;
    } st_t;

    st_t     st_d, st_q;
    adj_e    adj_new;
    quanta_t end_idx;
    quanta_t s_idx;
    logic    edge_now;

    assign sample_stb = st_q.sample_stb;
    assign sample_bit = st_q.sample_bit;
    assign bit_stb    = st_q.bit_stb;

    always_comb begin
        st_d            = st_q;
        st_d.sample_stb = 1'b0;
        st_d.bit_stb    = 1'b0;
        s_idx           = sp - quanta_t'(1);
        edge_now        = st_q.edge_seen | fall_pulse;
        adj_new         = st_q.adj;
        end_idx         = ntq - quanta_t'(1);

        if (tq_tick) begin
            // quantum 0 is the expected edge position, s_idx the sample quantum
            if (edge_now && (st_q.adj == ADJ_NONE) &&
                (st_q.q_cnt != '0) && (st_q.q_cnt != s_idx)) begin
                adj_new = (st_q.q_cnt < s_idx) ? ADJ_LONG : ADJ_SHORT;
            end
            case (adj_new)
                ADJ_LONG:  end_idx = ntq;
                ADJ_SHORT: end_idx = ntq - quanta_t'(2);
                default:   end_idx = ntq - quanta_t'(1);
            endcase

            if (st_q.q_cnt == s_idx) begin
                st_d.sample_stb = 1'b1;
                st_d.sample_bit = rx_lvl;
            end

            st_d.edge_seen = 1'b0;
            if (st_q.q_cnt >= end_idx) begin
                st_d.q_cnt   = '0;
                st_d.adj     = ADJ_NONE;
                st_d.bit_stb = 1'b1;
            end else begin
                st_d.q_cnt = st_q.q_cnt + quanta_t'(1);
                st_d.adj   = adj_new;
            end
        end else begin
            st_d.edge_seen = edge_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.adj        <= ADJ_NONE;
            st_q.sample_bit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/can_tx_arb.sv
module can_tx_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic tx_bit,
    input  logic bit_stb,
    input  logic sample_stb,
    input  logic sample_bit,
    output logic tx_out,
    output logic arb_lost,
    output logic tx_active,
    output logic tx_bit_cur
);
    typedef struct packed {
        logic active;
        logic bit_v;
        logic lost;
    } st_t;

    st_t st_d, st_q;

    assign tx_out     = ~(st_q.active & ~st_q.lost & ~st_q.bit_v);
    assign arb_lost   = st_q.lost;
    assign tx_active  = st_q.active;
    assign tx_bit_cur = st_q.bit_v;

    always_comb begin
        st_d        = st_q;
        st_d.active = tx_req;
        if (tx_req && !st_q.active) begin
            st_d.lost  = 1'b0;
            st_d.bit_v = tx_bit;
        end else if (st_q.active) begin
            if (bit_stb) st_d.bit_v = tx_bit;
            if (sample_stb && !st_q.lost && st_q.bit_v && !sample_bit)
                st_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.bit_v <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [QW-1:0]    cfg_ntq,
    input  logic [QW-1:0]    cfg_sp,
    input  logic             tx_req,
    input  logic             tx_bit,
    input  logic             rx_in,
    output logic             tx_out,
    output logic             arb_lost,
    output logic             sample_stb,
    output logic             sample_bit,
    output logic             bit_stb
);
    typedef struct packed {
        logic [BRP_W-1:0] brp;
        quanta_t          ntq;
        quanta_t          sp;
    } cfg_t;

    cfg_t    cfg_d, cfg_q;
    quanta_t ntq_clamped;
    logic    tq_tick;
    logic    rx_lvl;
    logic    fall_pulse;
    logic    tx_active_w;
    logic    tx_bit_w;

    assign ntq_clamped = clamp_ntq(cfg_ntq);

    always_comb begin
        cfg_d = cfg_q;
        if (!tx_active_w) begin
            cfg_d.brp = cfg_brp;
            cfg_d.ntq = ntq_clamped;
            cfg_d.sp  = clamp_sp(cfg_sp, ntq_clamped);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.brp <= '0;
            cfg_q.ntq <= quanta_t'(NTQ_MIN);
            cfg_q.sp  <= quanta_t'(6);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    can_tq_prescaler #(.BRP_W(BRP_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .brp     (cfg_q.brp),
        .tq_tick (tq_tick)
    );

    can_rx_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_in      (rx_in),
        .rx_lvl     (rx_lvl),
        .fall_pulse (fall_pulse)
    );

    can_bit_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tq_tick    (tq_tick),
        .ntq        (cfg_q.ntq),
        .sp         (cfg_q.sp),
        .rx_lvl     (rx_lvl),
        .fall_pulse (fall_pulse),
        .sample_stb (sample_stb),
        .sample_bit (sample_bit),
        .bit_stb    (bit_stb)
    );

    can_tx_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_req     (tx_req),
        .tx_bit     (tx_bit),
        .bit_stb    (bit_stb),
        .sample_stb (sample_stb),
        .sample_bit (sample_bit),
        .tx_out     (tx_out),
        .arb_lost   (arb_lost),
        .tx_active  (tx_active_w),
        .tx_bit_cur (tx_bit_w)
    );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic tx_bit_cur,
    input logic tx_out,
    input logic arb_lost,
    input logic sample_stb,
    input logic sample_bit,
    input logic bit_stb
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_stb)); // R3

    AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R3

    AST_BIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb); // R2

    AST_LOSS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !arb_lost && tx_bit_cur && sample_stb && !sample_bit)
        |=> (arb_lost && tx_out)); // R8

    AST_DOMINANT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !arb_lost && !tx_out && sample_stb) |=> !arb_lost); // R9

    AST_LOSS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(arb_lost) && $past(tx_active) && tx_active) |-> (arb_lost && tx_out)); // R10
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_active  (tx_active_w),
    .tx_bit_cur (tx_bit_w),
    .tx_out     (tx_out),
    .arb_lost   (arb_lost),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .bit_stb    (bit_stb)
);

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_brp = 6'd7;
    logic [4:0] cfg_ntq = 5'd15;
    logic [4:0] cfg_sp = 5'd10;
    logic       tx_req = 1'b0;
    logic       tx_bit = 1'b1;
    logic       bus_other = 1'b1;
    logic       rx_in;
    logic       tx_out, arb_lost, sample_stb, sample_bit, bit_stb;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int cur_p = 8;
    int cur_n = 15;
    int cur_s = 10;

    always #2 clk = ~clk;

    assign rx_in = tx_out & bus_other;

    can_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_ntq(cfg_ntq),
        .cfg_sp(cfg_sp), .tx_req(tx_req), .tx_bit(tx_bit), .rx_in(rx_in),
        .tx_out(tx_out), .arb_lost(arb_lost), .sample_stb(sample_stb),
        .sample_bit(sample_bit), .bit_stb(bit_stb)
    );

    function automatic int exp_ntq(input int v);
        if (v < 9) return 9;
        if (v > 20) return 20;
        return v;
    endfunction

    function automatic int exp_sp(input int v, input int n);
        if (v < 2) return 2;
        if (v > n - 1) return n - 1;
        return v;
    endfunction

    function automatic int exp_len(input int n, input int s, input int k);
        if (k == 1 || k == s) return n;
        if (k < s) return n + 1;
        return (k > n - 1) ? k : n - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_bit();
        do @(negedge clk); while (!bit_stb);
    endtask

    task automatic wait_sample();
        do @(negedge clk); while (!sample_stb);
    endtask

    task automatic set_cfg(input int brp, input int ntq, input int sp);
        cfg_brp = 6'(brp);
        cfg_ntq = 5'(ntq);
        cfg_sp  = 5'(sp);
        cur_p = brp + 1;
        cur_n = exp_ntq(ntq);
        cur_s = exp_sp(sp, cur_n);
        wait_bit();
        wait_bit();
    endtask

    task automatic measure_timing(input string req);
        int n;
        wait_bit();
        n = 0;
        do begin @(negedge clk); n++; end while (!sample_stb);
        chk(n == cur_s * cur_p, {req, " sample offset"}, n, cur_s * cur_p);
        do begin @(negedge clk); n++; end while (!bit_stb);
        chk(n == cur_n * cur_p, {req, " bit period"}, n, cur_n * cur_p);
    endtask

    // k1 is the quantum of the first falling edge; k2 = 0 means a single edge
    task automatic resync_case(input int k1, input int k2, input int exp, input string req);
        int n;
        wait_bit();
        n = 0;
        repeat ((k1 - 1) * cur_p + 1) begin @(negedge clk); n++; end
        bus_other = 1'b0;
        repeat (cur_p - 2) begin @(negedge clk); n++; end
        bus_other = 1'b1;
        if (k2 != 0) begin
            repeat ((k2 - 1) * cur_p + 1 - n) begin @(negedge clk); n++; end
            bus_other = 1'b0;
            repeat (cur_p - 2) begin @(negedge clk); n++; end
            bus_other = 1'b1;
        end
        do begin @(negedge clk); n++; end while (!bit_stb);
        chk(n == exp * cur_p, req, n, exp * cur_p);
        n = 0;
        do begin @(negedge clk); n++; end while (!bit_stb);
        chk(n == cur_n * cur_p, "R6 nominal bit after adjustment", n, cur_n * cur_p);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL WATCHDOG actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_out == 1'b1, "R1 tx_out", int'(tx_out), 1);
        chk(arb_lost == 1'b0, "R1 arb_lost", int'(arb_lost), 0);
        chk(!bit_stb && !sample_stb, "R1 strobes", int'({bit_stb, sample_stb}), 0);

        // R2 R3 random timing settings on a quiet bus
        for (int i = 0; i < 8; i++) begin
            int b, n, s;
            b = int'($urandom_range(0, 15));
            n = int'($urandom_range(9, 20));
            s = int'($urandom_range(2, n - 1));
            set_cfg(b, n, s);
            measure_timing("R2 R3 random");
        end

        // R2 R3 clamping corners
        set_cfg(3, 4, 0);
        measure_timing("R2 R3 clamp low");
        set_cfg(2, 31, 31);
        measure_timing("R2 R3 clamp high");

        // R3 sampled value
        set_cfg(7, 15, 10);
        wait_bit();
        bus_other = 1'b0;
        wait_sample();
        chk(sample_bit == 1'b0, "R3 sample dominant", int'(sample_bit), 0);
        wait_bit();
        bus_other = 1'b1;
        wait_sample();
        chk(sample_bit == 1'b1, "R3 sample recessive", int'(sample_bit), 1);

        // R4 R5 R6 directed edge zones, N=15 S=10 P=8
        resync_case(5, 0, 16, "R4 early edge lengthens");
        resync_case(2, 0, 16, "R4 edge in quantum 2");
        resync_case(12, 0, 14, "R5 late edge shortens");
        resync_case(14, 0, 14, "R5 edge in quantum N-1");
        resync_case(15, 0, 15, "R5 edge in final quantum");
        resync_case(1, 0, 15, "R6 edge in quantum 1");
        resync_case(10, 0, 15, "R6 edge at sample quantum");
        resync_case(3, 12, 16, "R6 one adjustment per bit");

        // R4 R5 R6 random edge positions
        for (int i = 0; i < 8; i++) begin
            int b, n, s, k;
            b = int'($urandom_range(4, 15));
            n = int'($urandom_range(9, 20));
            s = int'($urandom_range(2, n - 1));
            k = int'($urandom_range(1, n));
            set_cfg(b, n, s);
            resync_case(k, 0, exp_len(n, s, k), "R4 R5 random edge");
        end

        // R7 R8 R9 R10 arbitration
        set_cfg(7, 15, 10);
        wait_bit();
        tx_req = 1'b1;
        tx_bit = 1'b0;
        @(negedge clk);
        chk(tx_out == 1'b0, "R7 tx_out follows dominant", int'(tx_out), 0);
        wait_sample();
        @(negedge clk);
        chk(arb_lost == 1'b0, "R9 dominant sent", int'(arb_lost), 0);
        wait_bit();
        tx_bit = 1'b1;
        @(negedge clk);
        chk(tx_out == 1'b1, "R7 tx_out follows recessive", int'(tx_out), 1);
        wait_sample();
        @(negedge clk);
        chk(arb_lost == 1'b0, "R9 recessive matches", int'(arb_lost), 0);

        // R11 configuration held while transmitting
        cfg_ntq = 5'd12;
        wait_bit();
        begin
            int n;
            n = 0;
            do begin @(negedge clk); n++; end while (!bit_stb);
            chk(n == 15 * 8, "R11 config held", n, 15 * 8);
        end

        bus_other = 1'b0;
        wait_sample();
        chk(sample_bit == 1'b0, "R8 sampled dominant", int'(sample_bit), 0);
        @(negedge clk);
        chk(arb_lost == 1'b1, "R8 loss flagged", int'(arb_lost), 1);
        chk(tx_out == 1'b1, "R8 bus released", int'(tx_out), 1);
        wait_bit();
        tx_bit = 1'b0;
        bus_other = 1'b1;
        @(negedge clk);
        chk(tx_out == 1'b1, "R10 stays recessive", int'(tx_out), 1);
        wait_bit();
        chk(arb_lost == 1'b1, "R10 flag held", int'(arb_lost), 1);

        tx_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(tx_out == 1'b1, "R7 idle recessive", int'(tx_out), 1);
        wait_bit();
        begin
            int n;
            n = 0;
            do begin @(negedge clk); n++; end while (!bit_stb);
            chk(n == 12 * 8, "R11 config applied when idle", n, 12 * 8);
        end
        cfg_ntq = 5'd15;
        cur_n = 15;
        wait_bit();
        wait_bit();
        tx_req = 1'b1;
        tx_bit = 1'b0;
        @(negedge clk);
        chk(arb_lost == 1'b0, "R10 restart clears flag", int'(arb_lost), 0);
        chk(tx_out == 1'b0, "R10 restart drives bus", int'(tx_out), 0);
        wait_bit();
        tx_req = 1'b0;
        wait_bit();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule